// File: doc/BRIEF.md
# Prioritized Response and Data Transmitter

This block puts 32-bit words onto an on-chip bus. Two sources compete for the bus. The first is a short queue of pending acknowledge and negative-acknowledge requests. Each request names a target bus address, whether it is an ack or a nack, and whether it answers a transmit-side or a receive-side configuration. The second is inbound network data. A packet descriptor supplies the destination bus address and the byte length. A 32-bit payload source supplies the payload words. The block sends a header word to that address and then streams the payload words after it.

The arbiter only makes a choice between packets. Once a header has been loaded, the whole packet goes out before any queued response. At each boundary, any response waiting in the queue goes before the next data packet. When the queue is full, a new request is dropped without any signal back to the requester. Every word on the bus follows a valid/ready handshake: the word stays on the bus until the bus accepts it.

Top module: `resp_tx_mux`

## Requirements
- R1: A response word carries 0x5 (ack) or 0x6 (nack) in bits 31:28. Bit 27 is 1 when the request answers a transmit configuration and 0 when it answers a receive configuration. All other bits are zero. The word goes to the address stored with the request.
- R2: A data packet starts with a header word sent to the descriptor's address. The header has 0x4 in bits 31:28 and the 11-bit byte length in bits 27:17. All other bits are zero.
- R3: After the header come exactly ceil(length/4) payload words. Each is passed unchanged, in source order, to the same address. A length of zero gives a header and no payload.
- R4: When a packet boundary is reached and both a response and a packet descriptor are pending, the response is sent first.
- R5: A response request that arrives while a packet is in progress waits until the last payload word of that packet has been accepted.
- R6: The response queue holds ACK_DEPTH entries (4 by default). A request that arrives while the queue is full is discarded and never produces a bus word.
- R7: While bus_valid_o is high and bus_ready_i is low, the word and address stay unchanged in the next cycle.
- R8: During reset, bus_valid_o, rx_pkt_take_o and rx_word_pop_o are all low.
- R9: Queued responses leave in the order they arrived.
- R10: rx_pkt_take_o is a single-cycle pulse that marks when a descriptor is consumed. rx_word_pop_o is high only in a cycle where a payload word is accepted by the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_req_valid_i | input | 1 | Response request strobe, one per cycle |
| ack_req_addr_i | input | ADDR_W | Bus address for the response |
| ack_req_nack_i | input | 1 | 1 = nack, 0 = ack |
| ack_req_is_tx_i | input | 1 | 1 = answers a transmit configuration |
| rx_pkt_valid_i | input | 1 | A packet descriptor is available |
| rx_pkt_addr_i | input | ADDR_W | Destination bus address of the packet |
| rx_pkt_len_i | input | LEN_W | Packet length in bytes |
| rx_pkt_take_o | output | 1 | Descriptor consumed this cycle |
| rx_word_i | input | 32 | Head word of the payload source |
| rx_word_valid_i | input | 1 | Payload source is not empty |
| rx_word_pop_o | output | 1 | Remove the head payload word |
| bus_valid_o | output | 1 | Word on the bus is valid |
| bus_addr_o | output | ADDR_W | Target address of the bus word |
| bus_data_o | output | 32 | Bus word |
| bus_ready_i | input | 1 | Bus accepts the word this cycle |

## Verification
The assertions assume that the payload source behaves like a FIFO. Its head word and its valid flag must not change until rx_word_pop_o removes the word. The descriptor must also stay put until rx_pkt_take_o consumes it. The bench meets these assumptions by driving both sources from queues that change only one step after a pop or take was seen. The bench also throttles bus_ready_i with a pseudo-random pattern, and holds it low to build up response backlogs at known points.

// File: rtl/resp_tx_pkg.sv
package resp_tx_pkg;
   localparam int WORD_W      = 32;
   localparam int LEN_FIELD_W = 11;

   localparam logic [3:0] KIND_ACK   = 4'h5;
   localparam logic [3:0] KIND_NACK  = 4'h6;
   localparam logic [3:0] KIND_RXHDR = 4'h4;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RESP = 2'd1,
      SEQ_HDR  = 2'd2,
      SEQ_PAY  = 2'd3
   } seq_state_e;

   function automatic logic [WORD_W-1:0] resp_word(input logic nack, input logic is_tx);
      resp_word = {(nack ? KIND_NACK : KIND_ACK), is_tx, 27'd0};
   endfunction

   function automatic logic [WORD_W-1:0] hdr_word(input logic [LEN_FIELD_W-1:0] len);
      hdr_word = {KIND_RXHDR, len, 17'd0};
   endfunction
endpackage

// File: rtl/resp_ack_queue.sv
module resp_ack_queue #(
   parameter int AW    = 32,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [AW-1:0]    push_addr_i,
   input  logic             push_nack_i,
   input  logic             push_tx_i,
   input  logic             pop_i,
   output logic             nempty_o,
   output logic [AW-1:0]    head_addr_o,
   output logic             head_nack_o,
   output logic             head_tx_o,
   output logic [LVL_W-1:0] level_o
);
   localparam int ENT_W = AW + 2;

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [LVL_W-1:0] level;
   logic             full, do_push, do_pop;

   assign full    = (level == LVL_W'(DEPTH));
   assign do_push = push_i && !full;
   assign do_pop  = pop_i && (level != '0);

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= {push_addr_i, push_nack_i, push_tx_i};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign nempty_o    = (level != '0);
   assign head_addr_o = mem[rd_ptr][ENT_W-1:2];
   assign head_nack_o = mem[rd_ptr][1];
   assign head_tx_o   = mem[rd_ptr][0];
   assign level_o     = level;
endmodule

// File: rtl/resp_tx_seq.sv
module resp_tx_seq
   import resp_tx_pkg::*;
#(
   parameter int AW    = 32,
   parameter int LEN_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack_nempty_i,
   input  logic [AW-1:0]     ack_addr_i,
   input  logic              ack_nack_i,
   input  logic              ack_tx_i,
   output logic              ack_pop_o,
   input  logic              pkt_valid_i,
   input  logic [AW-1:0]     pkt_addr_i,
   input  logic [LEN_W-1:0]  pkt_len_i,
   output logic              pkt_take_o,
   input  logic [WORD_W-1:0] word_i,
   input  logic              word_valid_i,
   output logic              word_pop_o,
   output logic              bus_valid_o,
   output logic [AW-1:0]     bus_addr_o,
   output logic [WORD_W-1:0] bus_data_o,
   input  logic              bus_ready_i
);
   seq_state_e        state;
   logic [AW-1:0]     out_addr;
   logic [WORD_W-1:0] out_data;
   logic [LEN_W-1:0]  words_left, pkt_words;
   logic [LEN_W:0]    len_plus;
   logic              start_resp, start_pkt, accept;

   assign len_plus  = {1'b0, pkt_len_i} + (LEN_W + 1)'(3);
   assign pkt_words = {1'b0, len_plus[LEN_W:2]};

   assign start_resp = (state == SEQ_IDLE) && ack_nempty_i;
   assign start_pkt  = (state == SEQ_IDLE) && !ack_nempty_i && pkt_valid_i;
   assign ack_pop_o  = start_resp;
   assign pkt_take_o = start_pkt;

   assign bus_valid_o = (state == SEQ_RESP) || (state == SEQ_HDR) ||
                        ((state == SEQ_PAY) && word_valid_i);
   assign bus_data_o  = (state == SEQ_PAY) ? word_i : out_data;
   assign bus_addr_o  = out_addr;
   assign accept      = bus_valid_o && bus_ready_i;
   assign word_pop_o  = (state == SEQ_PAY) && accept;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SEQ_IDLE;
         out_addr   <= '0;
         out_data   <= '0;
         words_left <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (start_resp) begin
                  out_addr <= ack_addr_i;
                  out_data <= resp_word(ack_nack_i, ack_tx_i);
                  state    <= SEQ_RESP;
               end else if (start_pkt) begin
                  out_addr   <= pkt_addr_i;
                  out_data   <= hdr_word(pkt_len_i);
                  words_left <= pkt_words;
                  state      <= SEQ_HDR;
               end
            end
            SEQ_RESP: if (accept) state <= SEQ_IDLE;
            SEQ_HDR: begin
               if (accept) state <= (words_left == '0) ? SEQ_IDLE : SEQ_PAY;
            end
            SEQ_PAY: begin
               if (accept) begin
                  words_left <= words_left - 1'b1;
                  if (words_left == LEN_W'(1)) state <= SEQ_IDLE;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/resp_tx_mux.sv
module resp_tx_mux #(
   parameter int ADDR_W    = 32,
   parameter int ACK_DEPTH = 4,
   parameter int LEN_W     = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack_req_valid_i,
   input  logic [ADDR_W-1:0] ack_req_addr_i,
   input  logic              ack_req_nack_i,
   input  logic              ack_req_is_tx_i,
   input  logic              rx_pkt_valid_i,
   input  logic [ADDR_W-1:0] rx_pkt_addr_i,
   input  logic [LEN_W-1:0]  rx_pkt_len_i,
   output logic              rx_pkt_take_o,
   input  logic [31:0]       rx_word_i,
   input  logic              rx_word_valid_i,
   output logic              rx_word_pop_o,
   output logic              bus_valid_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [31:0]       bus_data_o,
   input  logic              bus_ready_i
);
   localparam int LVL_W = $clog2(ACK_DEPTH + 1);

   initial begin
      assert (LEN_W == resp_tx_pkg::LEN_FIELD_W) else $error("LEN_W must match the header length field");
      assert (ACK_DEPTH >= 1) else $error("ACK_DEPTH must be at least 1");
      assert (ADDR_W >= 1) else $error("ADDR_W must be at least 1");
   end

   logic              q_nempty, q_pop, q_nack, q_tx;
   logic [ADDR_W-1:0] q_addr;
   logic [LVL_W-1:0]  ack_level;

   resp_ack_queue #(.AW(ADDR_W), .DEPTH(ACK_DEPTH)) queue_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (ack_req_valid_i),
      .push_addr_i (ack_req_addr_i),
      .push_nack_i (ack_req_nack_i),
      .push_tx_i   (ack_req_is_tx_i),
      .pop_i       (q_pop),
      .nempty_o    (q_nempty),
      .head_addr_o (q_addr),
      .head_nack_o (q_nack),
      .head_tx_o   (q_tx),
      .level_o     (ack_level)
   );

   resp_tx_seq #(.AW(ADDR_W), .LEN_W(LEN_W)) seq_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ack_nempty_i (q_nempty),
      .ack_addr_i   (q_addr),
      .ack_nack_i   (q_nack),
      .ack_tx_i     (q_tx),
      .ack_pop_o    (q_pop),
      .pkt_valid_i  (rx_pkt_valid_i),
      .pkt_addr_i   (rx_pkt_addr_i),
      .pkt_len_i    (rx_pkt_len_i),
      .pkt_take_o   (rx_pkt_take_o),
      .word_i       (rx_word_i),
      .word_valid_i (rx_word_valid_i),
      .word_pop_o   (rx_word_pop_o),
      .bus_valid_o  (bus_valid_o),
      .bus_addr_o   (bus_addr_o),
      .bus_data_o   (bus_data_o),
      .bus_ready_i  (bus_ready_i)
   );
endmodule

// File: rtl/resp_tx_mux_chk.sv
module resp_tx_mux_chk #(
   parameter int ADDR_W    = 32,
   parameter int ACK_DEPTH = 4,
   localparam int LVL_W    = $clog2(ACK_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_pkt_take_o,
   input logic              rx_word_valid_i,
   input logic              rx_word_pop_o,
   input logic              bus_valid_o,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic [31:0]       bus_data_o,
   input logic              bus_ready_i,
   input logic [LVL_W-1:0]  ack_level
);
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_data_o) && $stable(bus_addr_o)); // R7

   AST_POP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_word_pop_o |-> bus_valid_o && bus_ready_i && rx_word_valid_i); // R10

   AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pkt_take_o |=> !rx_pkt_take_o); // R10

   AST_ACK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pkt_take_o |-> (ack_level == '0)); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ack_level <= LVL_W'(ACK_DEPTH)); // R6

   AST_TAKE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pkt_take_o |-> !bus_valid_o); // R5
endmodule

bind resp_tx_mux resp_tx_mux_chk #(.ADDR_W(ADDR_W), .ACK_DEPTH(ACK_DEPTH)) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .rx_pkt_take_o   (rx_pkt_take_o),
   .rx_word_valid_i (rx_word_valid_i),
   .rx_word_pop_o   (rx_word_pop_o),
   .bus_valid_o     (bus_valid_o),
   .bus_addr_o      (bus_addr_o),
   .bus_data_o      (bus_data_o),
   .bus_ready_i     (bus_ready_i),
   .ack_level       (ack_level)
);

// File: tb/resp_tx_mux_tb_top.sv
module resp_tx_mux_tb_top;
   localparam int AW    = 32;
   localparam int DEPTH = 4;
   localparam int LW    = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ack_req_valid_i = 1'b0;
   logic [AW-1:0] ack_req_addr_i = '0;
   logic          ack_req_nack_i = 1'b0;
   logic          ack_req_is_tx_i = 1'b0;
   logic          rx_pkt_valid_i = 1'b0;
   logic [AW-1:0] rx_pkt_addr_i = '0;
   logic [LW-1:0] rx_pkt_len_i = '0;
   logic          rx_pkt_take_o;
   logic [31:0]   rx_word_i = '0;
   logic          rx_word_valid_i = 1'b0;
   logic          rx_word_pop_o;
   logic          bus_valid_o;
   logic [AW-1:0] bus_addr_o;
   logic [31:0]   bus_data_o;
   logic          bus_ready_i = 1'b0;

   always #4 clk = ~clk;

   resp_tx_mux #(.ADDR_W(AW), .ACK_DEPTH(DEPTH), .LEN_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ack_req_valid_i(ack_req_valid_i), .ack_req_addr_i(ack_req_addr_i),
      .ack_req_nack_i(ack_req_nack_i), .ack_req_is_tx_i(ack_req_is_tx_i),
      .rx_pkt_valid_i(rx_pkt_valid_i), .rx_pkt_addr_i(rx_pkt_addr_i),
      .rx_pkt_len_i(rx_pkt_len_i), .rx_pkt_take_o(rx_pkt_take_o),
      .rx_word_i(rx_word_i), .rx_word_valid_i(rx_word_valid_i),
      .rx_word_pop_o(rx_word_pop_o), .bus_valid_o(bus_valid_o),
      .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o), .bus_ready_i(bus_ready_i)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // scoreboard and source models
   logic [63:0]   exp_q[$];
   string         exp_tag[$];
   logic [AW-1:0] pkt_addr_q[$];
   logic [LW-1:0] pkt_len_q[$];
   logic [31:0]   word_q[$];
   bit            hold_ready = 1'b1;
   logic [7:0]    lfsr = 8'hA5;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // source and monitor process: samples at negedge, drives just after posedge
   initial begin
      bit pend_stall;
      logic [63:0] stall_word;
      pend_stall = 1'b0;
      stall_word = '0;
      forever begin
         bit pop_w, take_w, fire;
         @(negedge clk);
         pop_w  = rx_word_pop_o;
         take_w = rx_pkt_take_o;
         fire   = bus_valid_o && bus_ready_i;
         if (rst_n) begin
            if (pend_stall)
               check(bus_valid_o && ({bus_addr_o, bus_data_o} == stall_word), "R7 held word",
                     {bus_addr_o, bus_data_o}, stall_word);
            pend_stall = bus_valid_o && !bus_ready_i;
            stall_word = {bus_addr_o, bus_data_o};
            if (pop_w) check(fire, "R10 pop without accept", 64'(fire), 64'd1);
            if (fire) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R3/R6 unexpected word", {bus_addr_o, bus_data_o}, 64'd0);
               end else begin
                  logic [63:0] e;
                  string t;
                  e = exp_q.pop_front();
                  t = exp_tag.pop_front();
                  check({bus_addr_o, bus_data_o} == e, t, {bus_addr_o, bus_data_o}, e);
               end
            end
         end
         @(posedge clk);
         #1;
         if (pop_w && word_q.size() > 0) void'(word_q.pop_front());
         if (take_w && pkt_addr_q.size() > 0) begin
            void'(pkt_addr_q.pop_front());
            void'(pkt_len_q.pop_front());
         end
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         bus_ready_i     = !hold_ready && (lfsr[0] || lfsr[3]);
         rx_word_valid_i = (word_q.size() > 0);
         rx_word_i       = (word_q.size() > 0) ? word_q[0] : 32'd0;
         rx_pkt_valid_i  = (pkt_addr_q.size() > 0);
         rx_pkt_addr_i   = (pkt_addr_q.size() > 0) ? pkt_addr_q[0] : '0;
         rx_pkt_len_i    = (pkt_len_q.size() > 0) ? pkt_len_q[0] : '0;
      end
   end

   // driver tasks: push stimulus and the expected words
   task automatic push_ack(input logic [AW-1:0] a, input bit nack, input bit tx, input bit expect_out, input string tag);
      @(posedge clk);
      #1;
      ack_req_valid_i = 1'b1;
      ack_req_addr_i  = a;
      ack_req_nack_i  = nack;
      ack_req_is_tx_i = tx;
      if (expect_out) begin
         exp_q.push_back({a, (nack ? 4'h6 : 4'h5), tx, 27'd0});
         exp_tag.push_back(tag);
      end
      @(posedge clk);
      #1;
      ack_req_valid_i = 1'b0;
   endtask

   task automatic add_pkt(input logic [AW-1:0] a, input int len, input logic [31:0] base, input string tag);
      int n;
      n = (len + 3) / 4;
      pkt_addr_q.push_back(a);
      pkt_len_q.push_back(LW'(len));
      exp_q.push_back({a, 4'h4, LW'(len), 17'd0});
      exp_tag.push_back({tag, " header"});
      for (int i = 0; i < n; i++) begin
         word_q.push_back(base + 32'(i));
         exp_q.push_back({a, base + 32'(i)});
         exp_tag.push_back({tag, " payload"});
      end
   endtask

   task automatic drain(input string tag);
      int w;
      w = 0;
      while (exp_q.size() > 0 && w < 3000) begin
         @(posedge clk);
         w++;
      end
      repeat (6) @(posedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, {tag, " all expected words seen"}, 64'(exp_q.size()), 64'd0);
      check(!bus_valid_o, {tag, " bus idle after drain"}, 64'(bus_valid_o), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!bus_valid_o && !rx_pkt_take_o && !rx_word_pop_o, "R8 reset outputs",
            {61'd0, bus_valid_o, rx_pkt_take_o, rx_word_pop_o}, 64'd0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      hold_ready = 1'b0;

      // R1: ack and nack formats, both flag values
      push_ack(32'h0000_1234, 1'b0, 1'b1, 1'b1, "R1 tx ack");
      push_ack(32'h0000_5678, 1'b1, 1'b0, 1'b1, "R1 rx nack");
      drain("R1");
      push_ack(32'hCAFE_0001, 1'b1, 1'b1, 1'b1, "R1 tx nack");
      push_ack(32'hCAFE_0002, 1'b0, 1'b0, 1'b1, "R1 rx ack");
      drain("R1 b");

      // R2 / R3: headers and payload counts
      add_pkt(32'h1000_0000, 10, 32'hA000_0000, "R2/R3 len10");
      drain("R3 len10");
      add_pkt(32'h2000_0000, 0, 32'hB000_0000, "R3 len0");
      add_pkt(32'h2000_0004, 4, 32'hB100_0000, "R3 len4");
      add_pkt(32'h2000_0008, 5, 32'hB200_0000, "R3 len5");
      add_pkt(32'h2000_000C, 2047, 32'hB300_0000, "R2 len2047");
      drain("R3 burst");

      // R4 / R5 / R9: responses wait for the packet, then beat the next one
      hold_ready = 1'b1;
      add_pkt(32'h3000_0000, 8, 32'hC000_0000, "R5 P1");
      repeat (5) @(posedge clk);
      push_ack(32'h3100_0001, 1'b0, 1'b1, 1'b1, "R4/R9 first queued");
      push_ack(32'h3100_0002, 1'b1, 1'b0, 1'b1, "R4/R9 second queued");
      add_pkt(32'h3200_0000, 3, 32'hC100_0000, "R4 P2");
      repeat (3) @(posedge clk);
      hold_ready = 1'b0;
      drain("R4 R5");

      // R6: overflow while the bus is stalled
      hold_ready = 1'b1;
      add_pkt(32'h4000_0000, 4, 32'hD000_0000, "R6 P3");
      repeat (4) @(posedge clk);
      for (int k = 0; k < DEPTH + 2; k++)
         push_ack(32'h4100_0000 + 32'(k), k[0], k[1], (k < DEPTH), "R6 kept");
      repeat (4) @(posedge clk);
      hold_ready = 1'b0;
      drain("R6");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule